// File: doc/BRIEF.md
# Shadow Memory Region Attribute Decoder

This block sits between the host address path and the memory/bus cycle logic. For any 20-bit memory address it says whether the access lands in one of the shadowable BIOS windows at the top of the first megabyte. For such an access it also says where the access is steered. Reads go either to internal DRAM or out to the external bus. Writes go to internal DRAM, go out to the external bus, or are dropped.

There are five windows of mixed size. The two lowest windows are 32 KiB each. The three higher windows are 64 KiB each and reach up to the top of the address space.

A control byte selects the behaviour. Each of its low five bits turns shadowing on for one window. One further bit write-protects every window that is turned on. The control byte is captured only when a recalculation strobe is asserted, and the captured value governs decoding from the following cycle on. Address decoding itself is combinational against the captured value.

Top module: `shadow_attr_decoder`

## Requirements
- R1: Window 0 spans 0xC0000..0xC7FFF and window 1 spans 0xC8000..0xCFFFF. An address in one of them asserts `region_hit` and reports `region_idx` 0 or 1 respectively.
- R2: Windows 2, 3 and 4 are 64 KiB each and start at 0xD0000, 0xE0000 and 0xF0000. An address in one of them asserts `region_hit` and reports `region_idx` 2, 3 or 4.
- R3: Captured control bit i (i = 0..4) enables window i. An address in an enabled window asserts `rd_internal`.
- R4: For an enabled window with captured control bit 5 clear, `wr_internal` is asserted and `wr_discard` is low.
- R5: For an enabled window with captured control bit 5 set, `wr_discard` is asserted and `wr_internal` is low.
- R6: For a disabled window, `rd_internal` is low and `wr_external` is asserted, whatever the value of bit 5.
- R7: An address below 0xC0000 gives `region_hit` = 0, `region_idx` = 0, and all four steering flags low.
- R8: `shadow_cfg` is captured at a rising clock edge where `recalc_stb` is high. The outputs use the new value from that edge on. While the strobe is low, changes on `shadow_cfg` have no effect.
- R9: Whenever `region_hit` is high, exactly one of `wr_internal`, `wr_external` and `wr_discard` is high.
- R10: After reset the captured control byte is 0x00, so every window is disabled.
- R11: Control bits 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recalc_stb | input | 1 | Capture strobe for the control byte |
| shadow_cfg | input | 8 | Control byte: bits 0..4 enable the windows, bit 5 write-protects them |
| mem_addr | input | 20 | Access address |
| region_hit | output | 1 | Address lies in one of the five windows |
| region_idx | output | 3 | Index of the window that was hit (0 when there is no hit) |
| rd_internal | output | 1 | Read is served from internal DRAM |
| wr_internal | output | 1 | Write goes to internal DRAM |
| wr_external | output | 1 | Write goes to the external bus |
| wr_discard | output | 1 | Write is dropped |

## Verification
A control-byte capture and an address lookup can fall in the same cycle. The bench provokes this by raising the strobe with a new control byte in the same cycle that it moves the address into a window whose enable bit is changing. Within that cycle the outputs must still reflect the old byte, and from the next cycle they must reflect the new one. A behavioural model updates its own copy of the byte at the edge and predicts both cycles, and every cycle's outputs are compared against it.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   typedef struct packed {
      logic rd_int;
      logic wr_int;
      logic wr_ext;
      logic wr_blk;
   } shadow_attr_t;

   // Base address of window idx: small windows first, then large ones.
   function automatic longint win_base(input int idx, input longint origin,
                                       input int n_small, input int small_log2,
                                       input int large_log2);
      longint b;
      if (idx < n_small)
         b = origin + (longint'(idx) << small_log2);
      else
         b = origin + (longint'(n_small) << small_log2)
             + (longint'(idx - n_small) << large_log2);
      return b;
   endfunction

   function automatic longint win_size(input int idx, input int n_small,
                                       input int small_log2, input int large_log2);
      return (idx < n_small) ? (64'd1 << small_log2) : (64'd1 << large_log2);
   endfunction

endpackage

// File: rtl/shadow_ctrl_reg.sv
module shadow_ctrl_reg #(
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CTRL_W-1:0] din,
   output logic [CTRL_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end

   assert_ctrl_capture_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q == $past(din)));

   assert_ctrl_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

endmodule

// File: rtl/shadow_region_match.sv
module shadow_region_match #(
   parameter int     ADDR_W      = 20,
   parameter int     NUM_REGIONS = 5,
   parameter longint ORIGIN      = 64'hC0000,
   parameter int     N_SMALL     = 2,
   parameter int     SMALL_LOG2  = 15,
   parameter int     LARGE_LOG2  = 16,
   localparam int    IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic [NUM_REGIONS-1:0] hit_vec,
   output logic                   hit_any,
   output logic [IDX_W-1:0]       hit_idx
);

   localparam longint TOP_END = shadow_pkg::win_base(NUM_REGIONS, ORIGIN, N_SMALL,
                                                     SMALL_LOG2, LARGE_LOG2);

   if (N_SMALL > NUM_REGIONS) begin : g_bad_small
      $error("N_SMALL exceeds NUM_REGIONS");
   end
   if (TOP_END > (64'd1 << ADDR_W)) begin : g_bad_span
      $error("windows extend past the address space");
   end

   for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_win
      localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(shadow_pkg::win_base(
         gi, ORIGIN, N_SMALL, SMALL_LOG2, LARGE_LOG2));
      localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(shadow_pkg::win_base(
         gi, ORIGIN, N_SMALL, SMALL_LOG2, LARGE_LOG2)
         + shadow_pkg::win_size(gi, N_SMALL, SMALL_LOG2, LARGE_LOG2));
      assign hit_vec[gi] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < NUM_REGIONS; i++)
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      hit_any = |hit_vec;
   end

   always_comb begin
      assert_window_onehot_R1 : assert ($onehot0(hit_vec));
   end

endmodule

// File: rtl/shadow_attr_gen.sv
module shadow_attr_gen #(
   parameter int NUM_REGIONS = 5
) (
   input  logic [NUM_REGIONS-1:0] hit_vec,
   input  logic [NUM_REGIONS-1:0] en_bits,
   input  logic                   wp,
   output shadow_pkg::shadow_attr_t attr
);

   logic win_on;
   logic in_win;

   always_comb begin
      in_win      = |hit_vec;
      win_on      = |(hit_vec & en_bits);
      attr.rd_int = win_on;
      attr.wr_int = win_on & ~wp;
      attr.wr_blk = win_on & wp;
      attr.wr_ext = in_win & ~win_on;
   end

   always_comb begin
      assert_one_write_path_R9 : assert (
         $countones({attr.wr_int, attr.wr_ext, attr.wr_blk}) == {31'd0, in_win});
   end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder #(
   parameter int     ADDR_W      = 20,
   parameter int     CTRL_W      = 8,
   parameter int     NUM_REGIONS = 5,
   parameter int     WP_BIT      = 5,
   parameter longint ORIGIN      = 64'hC0000,
   parameter int     N_SMALL     = 2,
   parameter int     SMALL_LOG2  = 15,
   parameter int     LARGE_LOG2  = 16,
   localparam int    IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              recalc_stb,
   input  logic [CTRL_W-1:0] shadow_cfg,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              region_hit,
   output logic [IDX_W-1:0]  region_idx,
   output logic              rd_internal,
   output logic              wr_internal,
   output logic              wr_external,
   output logic              wr_discard
);

   if (NUM_REGIONS > CTRL_W) begin : g_bad_ctrl
      $error("more windows than control bits");
   end
   if (WP_BIT < NUM_REGIONS || WP_BIT >= CTRL_W) begin : g_bad_wp
      $error("write-protect bit must lie above the enable bits");
   end

   logic [CTRL_W-1:0]      ctrl_q;
   logic [NUM_REGIONS-1:0] hit_vec;
   shadow_pkg::shadow_attr_t attr;
   logic                   unused_ctrl_bits;

   assign unused_ctrl_bits = ^ctrl_q;

   shadow_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .load (recalc_stb),
      .din  (shadow_cfg),
      .q    (ctrl_q)
   );

   shadow_region_match #(
      .ADDR_W     (ADDR_W),
      .NUM_REGIONS(NUM_REGIONS),
      .ORIGIN     (ORIGIN),
      .N_SMALL    (N_SMALL),
      .SMALL_LOG2 (SMALL_LOG2),
      .LARGE_LOG2 (LARGE_LOG2)
   ) u_match (
      .addr   (mem_addr),
      .hit_vec(hit_vec),
      .hit_any(region_hit),
      .hit_idx(region_idx)
   );

   shadow_attr_gen #(.NUM_REGIONS(NUM_REGIONS)) u_attr (
      .hit_vec(hit_vec),
      .en_bits(ctrl_q[NUM_REGIONS-1:0]),
      .wp     (ctrl_q[WP_BIT]),
      .attr   (attr)
   );

   assign rd_internal = attr.rd_int;
   assign wr_internal = attr.wr_int;
   assign wr_external = attr.wr_ext;
   assign wr_discard  = attr.wr_blk;

   assert_idx_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      region_idx < IDX_W'(NUM_REGIONS));

   assert_no_hit_quiet_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !region_hit |-> !(rd_internal || wr_internal || wr_external || wr_discard)
                      && region_idx == '0);

   assert_read_int_needs_hit_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_internal |-> region_hit);

   assert_protect_blocks_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_discard |-> (rd_internal && !wr_internal));

endmodule

// File: tb/tb_shadow_attr_decoder.sv
module tb_shadow_attr_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        recalc_stb = 1'b0;
   logic [7:0]  shadow_cfg = 8'h00;
   logic [19:0] mem_addr = 20'h0;
   logic        region_hit;
   logic [2:0]  region_idx;
   logic        rd_internal, wr_internal, wr_external, wr_discard;

   int n_checks = 0;
   int n_fails  = 0;
   int model_ctrl = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   shadow_attr_decoder dut (
      .clk(clk), .rst_n(rst_n), .recalc_stb(recalc_stb), .shadow_cfg(shadow_cfg),
      .mem_addr(mem_addr), .region_hit(region_hit), .region_idx(region_idx),
      .rd_internal(rd_internal), .wr_internal(wr_internal),
      .wr_external(wr_external), .wr_discard(wr_discard)
   );

   // Reference model: captured byte follows the strobe at each rising edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_ctrl <= 0;
      else if (recalc_stb) model_ctrl <= int'(shadow_cfg);
   end

   task automatic compare(input string tag);
      int a, idx, hit, en, wp;
      int e_rd, e_wi, e_we, e_wb;
      string rq;
      a   = int'(mem_addr);
      hit = (a >= 'hC0000) ? 1 : 0;
      if (!hit)           idx = 0;
      else if (a < 'hC8000) idx = 0;
      else if (a < 'hD0000) idx = 1;
      else                idx = (a >> 16) - 'hD + 2;
      en   = hit ? ((model_ctrl >> idx) & 1) : 0;
      wp   = (model_ctrl >> 5) & 1;
      e_rd = en;
      e_wi = en & ~wp & 1;
      e_wb = en & wp;
      e_we = hit & ~en & 1;
      if (!hit) rq = "R7";
      else if (en && wp) rq = "R5";
      else if (en) rq = "R4";
      else rq = "R6";
      n_checks++;
      if (int'(region_hit) != hit || int'(region_idx) != idx ||
          int'(rd_internal) != e_rd || int'(wr_internal) != e_wi ||
          int'(wr_external) != e_we || int'(wr_discard) != e_wb) begin
         n_fails++;
         $display("FAIL %s/%s addr=%h ctrl=%h got hit=%0d idx=%0d rd=%0d wi=%0d we=%0d wb=%0d exp hit=%0d idx=%0d rd=%0d wi=%0d we=%0d wb=%0d",
                  rq, tag, mem_addr, model_ctrl[7:0], region_hit, region_idx,
                  rd_internal, wr_internal, wr_external, wr_discard,
                  hit, idx, e_rd, e_wi, e_we, e_wb);
      end
   endtask

   // Drive at the falling edge, compare just after, then cross the rising edge.
   task automatic step(input logic [19:0] a, input logic stb, input logic [7:0] cfg,
                       input string tag);
      mem_addr   = a;
      recalc_stb = stb;
      shadow_cfg = cfg;
      #1;
      compare(tag);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sweep(input string tag);
      logic [19:0] pts [14] = '{20'h00000, 20'h7FFFF, 20'hBFFFF, 20'hC0000, 20'hC7FFF,
                                20'hC8000, 20'hCFFFF, 20'hD0000, 20'hDFFFF, 20'hE0000,
                                20'hEFFFF, 20'hF0000, 20'hF8000, 20'hFFFFF};
      for (int k = 0; k < 14; k++) step(pts[k], 1'b0, 8'h00, tag);
   endtask

   task automatic load_cfg(input logic [7:0] v);
      step(20'h00000, 1'b1, v, "load");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state, all windows disabled; R1 R2 window edges; R7 low addresses
      sweep("reset_R10");
      // R3 R4: all enabled, unprotected
      load_cfg(8'h1F);  sweep("all_on_R3");
      // R5: all enabled, protected
      load_cfg(8'h3F);  sweep("all_prot_R5");
      // R6: alternating windows, with and without bit 5
      load_cfg(8'h15);  sweep("alt_a_R6");
      load_cfg(8'h2A);  sweep("alt_b_R6");
      // R11: bits 6 and 7 set must not change anything
      load_cfg(8'hCA);  sweep("hi_bits_R11");
      load_cfg(8'h40);  sweep("hi_only_R11");
      // R8: byte changes with strobe low are ignored
      load_cfg(8'h01);
      step(20'hC0000, 1'b0, 8'h20, "nostb_R8");
      step(20'hC0000, 1'b0, 8'h00, "nostb_R8");
      // R8: strobe and lookup in the same cycle: old byte this cycle, new byte next
      step(20'hC8000, 1'b1, 8'h22, "same_cycle_old_R8");
      step(20'hC8000, 1'b0, 8'h00, "same_cycle_new_R8");
      step(20'hF0000, 1'b1, 8'h10, "same_cycle_old_R8");
      step(20'hF0000, 1'b0, 8'h00, "same_cycle_new_R8");
      // R9: every hit above also checked for a single write path; extra walk
      for (int c = 0; c < 64; c++) begin
         load_cfg(8'(c));
         step(20'(32'hC0000 + c * 32'h1000), 1'b0, 8'h00, "walk_R9");
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete (got timeout, expected finish)");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule